// File: doc/BRIEF.md
# Serial Configuration Register Target

This block is a two-wire serial bus target that gives a bus master read and write access to a 256-byte configuration register file of a clock generator. The bus pins are sampled with a faster system clock. The block recognises START, repeated START and STOP conditions and answers to one fixed 7-bit device address. It accepts a register address byte and then any number of data bytes.

An address pointer survives from one transaction to the next. Because of this, a read that has no address phase continues where the last access stopped. A random read is made from a write that carries only the register address, followed by a repeated START and a read. Reads stream consecutive bytes for as long as the master acknowledges them, and the pointer rolls over at the top of the file. The block drives SDA only as an open-drain pull-down enable. Clock stretching, general call and 10-bit addressing are not supported.

Top module: `i2c_cfg_slave`

## Requirements
- R1: The first byte after any START is {device address, R/W}, with R/W in bit 0 (1 = read). With the default address 69h the write byte is D2h and the read byte is D3h. On a match the target pulls SDA low during the 9th clock.
- R2: A first byte whose upper seven bits differ from the device address gets no acknowledge. The target then keeps SDA released until the next START or STOP, and later bytes change no register.
- R3: In a write, the second byte loads the pointer and every further byte is stored at the pointer, after which the pointer steps by one. Each of these bytes is acknowledged.
- R4: The pointer always holds one more than the location last read or written, so a read with no address phase returns location n+1.
- R5: A write that carries only a register address, followed by a repeated START and a read, returns the byte at that address and stores nothing.
- R6: In a read, the target shifts out the byte at the pointer MSB first. A master acknowledge steps the pointer and sends the next byte. A master no-acknowledge releases SDA until the next START or STOP.
- R7: The pointer steps from FFh to 00h, both in writes and in reads.
- R8: The target changes its SDA drive only while SCL is low. SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP.
- R9: After reset, location k holds k XOR 5Ah, the pointer is 00h and SDA is released.
- R10: A START or STOP that arrives before the 8th bit of a data byte discards that byte, so no partial value is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8 times the bus bit rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1, release when 0 |

## Verification
The bench pushes the pointer across the FFh boundary in a burst write and again in a sequential read. A design without the rollover would read back the wrong bytes, and one that increments the pointer at the wrong time would return the wrong location on the next current-address read. It ends data bytes early with a STOP and with a repeated START, which catches a design that commits half-shifted data. It sends a foreign device address followed by data bytes, and a design that acknowledged them or stored the data would show SDA pulled low or a changed register. A monitor on the pins flags any rise of the SDA drive while SCL is high, because such a rise would look like a false START or STOP on the bus.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o,
  output logic sda_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  // bus idles high; reset to 1 so no false condition appears
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o   = scl_ff[STAGES-1];
  assign sda_o   = sda_ff[STAGES-1];
  assign rise_o  = scl_o & ~scl_q;
  assign fall_o  = ~scl_o & scl_q;
  assign start_o = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o  = scl_o & scl_q & ~sda_q & sda_o;

  p_events_exclusive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_o, stop_o, rise_o, fall_o}));
endmodule

// File: rtl/i2c_cfg_ptr.sv
module i2c_cfg_ptr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (load_i) ptr_o <= load_val_i;
    else if (inc_i)  ptr_o <= ptr_o + 1'b1;
  end

  // any change not caused by a load is a single step with rollover
  p_ptr_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_o != $past(ptr_o)) && !$past(load_i) |-> ptr_o == ADDR_W'($past(ptr_o) + 1'b1));
endmodule

// File: rtl/i2c_cfg_regfile.sv
module i2c_cfg_regfile #(
  parameter int          ADDR_W  = 8,
  parameter logic [7:0]  DEF_XOR = 8'h5A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'(i) ^ DEF_XOR;
    end else if (we_i) begin
      mem[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         ADDR_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] DEF_XOR     = 8'h5A
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  logic scl_s, sda_s, start, stop, rise, fall;
  state_e st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg, tx;
  logic rw_q, mack_q;
  logic ptr_load, ptr_inc, we;
  logic [ADDR_W-1:0] ptr;
  logic [7:0] rd_data;
  logic byte_done;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .start_o(start), .stop_o(stop),
    .rise_o(rise), .fall_o(fall), .sda_o(sda_s)
  );

  i2c_cfg_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk_i, .rst_ni,
    .load_i(ptr_load), .load_val_i(shreg[ADDR_W-1:0]),
    .inc_i(ptr_inc), .ptr_o(ptr)
  );

  i2c_cfg_regfile #(.ADDR_W(ADDR_W), .DEF_XOR(DEF_XOR)) u_regs (
    .clk_i, .rst_ni,
    .we_i(we), .addr_i(ptr), .wdata_i(shreg), .rdata_o(rd_data)
  );

  assign byte_done = fall && (cnt == CNT_W'(BYTE_W));

  always_comb begin
    ptr_load = 1'b0;
    ptr_inc  = 1'b0;
    we       = 1'b0;
    if (byte_done) begin
      case (st)
        ST_REG:   ptr_load = 1'b1;
        ST_WDATA: begin we = 1'b1; ptr_inc = 1'b1; end
        ST_RDATA: ptr_inc = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      shreg  <= '0;
      tx     <= '0;
      rw_q   <= 1'b0;
      mack_q <= 1'b0;
    end else if (start) begin
      st  <= ST_DEV;
      cnt <= '0;
    end else if (stop) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        ST_DEV, ST_REG, ST_WDATA: begin
          if (rise) begin
            shreg <= {shreg[BYTE_W-2:0], sda_s};
            cnt   <= cnt + 1'b1;
          end else if (byte_done) begin
            cnt <= '0;
            if (st == ST_DEV) begin
              if (shreg[7:1] == DEV_ADDR) begin
                rw_q <= shreg[0];
                st   <= ST_DEV_ACK;
              end else begin
                st <= ST_IGNORE;
              end
            end else if (st == ST_REG) begin
              st <= ST_REG_ACK;
            end else begin
              st <= ST_WDATA_ACK;
            end
          end
        end
        ST_DEV_ACK: if (fall) begin
          st <= rw_q ? ST_RDATA : ST_REG;
          tx <= rd_data;
        end
        ST_REG_ACK, ST_WDATA_ACK: if (fall) st <= ST_WDATA;
        ST_RDATA: begin
          if (rise) cnt <= cnt + 1'b1;
          else if (byte_done) begin
            st  <= ST_RACK;
            cnt <= '0;
          end else if (fall) begin
            tx <= {tx[BYTE_W-2:0], 1'b0};
          end
        end
        ST_RACK: begin
          if (rise) mack_q <= ~sda_s;
          else if (fall) begin
            if (mack_q) begin
              st <= ST_RDATA;
              tx <= rd_data;
            end else begin
              st <= ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = (st == ST_DEV_ACK) || (st == ST_REG_ACK) || (st == ST_WDATA_ACK)
                 || ((st == ST_RDATA) && !tx[BYTE_W-1]);

  p_oe_rise_scl_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s);

  p_ignore_silent_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IGNORE) |-> !sda_oe_o);

  p_no_write_outside_data_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |-> (st == ST_WDATA) && !scl_s);
endmodule

// File: tb/i2c_cfg_slave_tb.sv
module i2c_cfg_slave_tb;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  int total = 0;
  int bad = 0;
  int r8_viol = 0;
  int r2_viol = 0;
  logic watch_r2 = 1'b0;
  logic oe_prev = 1'b0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  i2c_cfg_slave u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe)
  );

  always @(negedge clk) begin
    if (sda_oe && !oe_prev && scl_m) r8_viol++;
    if (watch_r2 && sda_oe) r2_viol++;
    oe_prev <= sda_oe;
  end

  // {register address, data}
  localparam logic [15:0] VEC [6] = '{16'h103C, 16'h11C3, 16'h8000,
                                      16'h7FFF, 16'h01A5, 16'hC496};

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic bus_bit(input logic b, output logic s);
    sda_m = b; tick(H);
    scl_m = 1'b1; tick(H / 2);
    s = sda_line; tick(H / 2);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      b[i] = s;
    end
    bus_bit(~give_ack, s);
  endtask

  task automatic write_one(input logic [7:0] a, input logic [7:0] d);
    logic ack;
    bus_start();
    send_byte(8'hD2, ack); chk("R1 dev ack", {7'd0, ack}, 8'd1);
    send_byte(a, ack);     chk("R3 addr ack", {7'd0, ack}, 8'd1);
    send_byte(d, ack);     chk("R3 data ack", {7'd0, ack}, 8'd1);
    bus_stop();
  endtask

  task automatic rand_read(input logic [7:0] a, output logic [7:0] d);
    logic ack;
    bus_start();
    send_byte(8'hD2, ack);
    send_byte(a, ack);
    bus_start();
    send_byte(8'hD3, ack); chk("R1 read dev ack", {7'd0, ack}, 8'd1);
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  task automatic cur_read(output logic [7:0] d);
    logic ack;
    bus_start();
    send_byte(8'hD3, ack);
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  initial begin
    logic [7:0] d;
    logic ack;
    logic s;
    tick(4);
    chk("R9 sda released in reset", {7'd0, sda_oe}, 8'd0);
    rst_ni = 1'b1;
    tick(4);
    chk("R9 sda released after reset", {7'd0, sda_oe}, 8'd0);

    // R9 / R4: pointer 00h after reset, location 0 default
    cur_read(d);
    chk("R9 default loc 00", d, 8'h5A);
    cur_read(d);
    chk("R4 current read n+1", d, 8'h01 ^ 8'h5A);

    // R1 R3 R5: table of single writes, each read back by random read
    for (int i = 0; i < 6; i++) begin
      write_one(VEC[i][15:8], VEC[i][7:0]);
      rand_read(VEC[i][15:8], d);
      chk("R5 random read back", d, VEC[i][7:0]);
    end

    // R4: after reading C4h, next current read is C5h default
    cur_read(d);
    chk("R4 current read after random", d, 8'hC5 ^ 8'h5A);

    // R3 R7: burst across FFh
    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'hFE, ack);
    send_byte(8'h11, ack);
    send_byte(8'h22, ack);
    send_byte(8'h33, ack); chk("R3 burst ack", {7'd0, ack}, 8'd1);
    bus_stop();

    // R6 R7: sequential read across FFh
    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'hFE, ack);
    bus_start();
    send_byte(8'hD3, ack);
    recv_byte(1'b1, d); chk("R6 seq byte FE", d, 8'h11);
    recv_byte(1'b1, d); chk("R7 seq byte FF", d, 8'h22);
    recv_byte(1'b0, d); chk("R7 seq byte 00 wrapped", d, 8'h33);
    chk("R6 released after nack", {7'd0, sda_oe}, 8'd0);
    bus_stop();
    cur_read(d);
    chk("R4 pointer after seq read", d, 8'hA5);

    // R2: foreign address, data must not land
    watch_r2 = 1'b1;
    bus_start();
    send_byte(8'hD0, ack); chk("R2 foreign addr nack", {7'd0, ack}, 8'd0);
    send_byte(8'h20, ack); chk("R2 reg byte ignored", {7'd0, ack}, 8'd0);
    send_byte(8'hEE, ack);
    bus_stop();
    watch_r2 = 1'b0;
    chk("R2 sda never driven", 8'(r2_viol), 8'd0);
    rand_read(8'h20, d);
    chk("R2 no store", d, 8'h20 ^ 8'h5A);

    // R5: address-only write stores nothing
    rand_read(8'h40, d);
    chk("R5 address only write", d, 8'h40 ^ 8'h5A);

    // R10: STOP in the middle of a data byte
    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'h50, ack);
    for (int i = 0; i < 4; i++) bus_bit(1'b0, s);
    bus_stop();
    rand_read(8'h50, d);
    chk("R10 stop mid byte", d, 8'h50 ^ 8'h5A);

    // R10: repeated START in the middle of a data byte
    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'h51, ack);
    for (int i = 0; i < 3; i++) bus_bit(1'b0, s);
    bus_start();
    send_byte(8'hD3, ack);
    recv_byte(1'b0, d);
    bus_stop();
    chk("R10 restart mid byte", d, 8'h51 ^ 8'h5A);

    chk("R8 drive rises only with scl low", 8'(r8_viol), 8'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule